// File: doc/BRIEF.md
# Chainable Two-Bit Shift Slice and Wide One-Place Shifter

This block moves a data word by exactly one bit position, towards the most significant end or towards the least significant end. A right move is either logical, which brings a zero in at the top, or arithmetic, which repeats the sign bit at the top. A left move always brings a zero in at the bottom, whatever the mode setting. The whole path is combinational. There is no clock, no reset and no internal state.

The basic unit is a two-bit slice. Each slice reports the bit that it pushes out at either end and accepts a fill bit from each neighbour. The top module places a parameterised number of these slices side by side. Each slice's spill outputs feed the neighbouring slice's fill inputs, which forms one wide shifter. The bits that leave the two outer slices become the spill outputs of the wide shifter.

Top module: `chain_shifter`

## Requirements
- R1: With shiftRight=0 and arithMode=0, dataOut[i] equals dataIn[i-1] for every i above 0, and dataOut[0] is 0.
- R2: With shiftRight=0 and arithMode=1, the result equals the logical left result: dataOut[0] is 0 and the remaining bits come from one place lower.
- R3: With shiftRight=1 and arithMode=0, dataOut[i] equals dataIn[i+1] for every i below the top bit, and the top bit of dataOut is 0.
- R4: With shiftRight=1 and arithMode=1, dataOut[i] equals dataIn[i+1] for every i below the top bit, and the top bit of dataOut equals the top bit of dataIn.
- R5: spillLeft equals the top bit of dataIn on a left move and is 0 on a right move.
- R6: spillRight equals dataIn[0] on a right move and is 0 on a left move.
- R7: Bits cross the internal slice boundaries. The upper bit of one slice enters the lower bit of the next slice up on a left move, and the lower bit of a slice enters the upper bit of the next slice down on a right move.
- R8: The outputs follow a change on any input with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 2*NUM_SLICES | Word to be shifted |
| shiftRight | input | 1 | 0 moves towards the MSB, 1 moves towards the LSB |
| arithMode | input | 1 | 0 logical, 1 sign-preserving on right moves |
| dataOut | output | 2*NUM_SLICES | Shifted word |
| spillLeft | output | 1 | Bit pushed out of the MSB end |
| spillRight | output | 1 | Bit pushed out of the LSB end |

## Verification
Every 8-bit input word is applied under each of the four direction and mode pairs. This shows the zero fill apart from the sign fill, and it shows that the arithmetic setting does not change a left move. Words with a single set bit on either side of a slice boundary show whether the links between slices carry data. Words whose top or bottom bit is set show whether each spill output reports the right bit and stays quiet in the other direction. A final mid-cycle input change with no clock edge between drive and sample shows that the path is purely combinational.

// File: rtl/shift_pkg.sv
package shift_pkg;

  // Strobes from the decode to every slice datapath
  typedef struct packed {
    logic moveLeft;   // select the lower neighbour's bit for the low position
    logic moveRight;  // select the upper neighbour's bit for the high position
    logic edgeFill;   // value entering the top of the word on a right move
  } shift_strobe_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic          shiftRight,
  input  logic          arithMode,
  input  logic          wordMsb,
  output shift_strobe_t strobe
);

  always_comb begin
    strobe.moveRight = shiftRight;
    strobe.moveLeft  = ~shiftRight;
    // a left move never repeats the sign, so only right moves use the mode
    strobe.edgeFill  = shiftRight & arithMode & wordMsb;
  end

endmodule

// File: rtl/shift_slice2.sv
module shift_slice2
  import shift_pkg::*;
(
  input  shift_strobe_t strobe,
  input  logic [1:0]    dataIn,
  input  logic          fillFromLeft,
  input  logic          fillFromRight,
  output logic [1:0]    dataOut,
  output logic          spillLeft,
  output logic          spillRight
);

  always_comb begin
    if (strobe.moveRight) begin
      dataOut = {fillFromLeft, dataIn[1]};
    end else begin
      dataOut = {dataIn[0], fillFromRight};
    end
    spillLeft  = strobe.moveLeft  & dataIn[1];
    spillRight = strobe.moveRight & dataIn[0];
  end

endmodule

// File: rtl/chain_shifter.sv
module chain_shifter
  import shift_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 4
) (
  input  logic [2*NUM_SLICES-1:0] dataIn,
  input  logic                    shiftRight,
  input  logic                    arithMode,
  output logic [2*NUM_SLICES-1:0] dataOut,
  output logic                    spillLeft,
  output logic                    spillRight
);

  localparam int unsigned WIDTH = 2 * NUM_SLICES;
  localparam int unsigned TOP   = WIDTH - 1;

  shift_strobe_t strobe;
  logic [NUM_SLICES-1:0] sliceSpillL;
  logic [NUM_SLICES-1:0] sliceSpillR;

  shift_ctrl ctrl_i (
    .shiftRight (shiftRight),
    .arithMode  (arithMode),
    .wordMsb    (dataIn[TOP]),
    .strobe     (strobe)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic fromLeft;
    logic fromRight;

    if (k == NUM_SLICES - 1) begin : g_top_end
      assign fromLeft = strobe.edgeFill;
    end else begin : g_top_link
      assign fromLeft = sliceSpillR[k+1];
    end

    if (k == 0) begin : g_low_end
      assign fromRight = 1'b0;
    end else begin : g_low_link
      assign fromRight = sliceSpillL[k-1];
    end

    shift_slice2 slice_i (
      .strobe        (strobe),
      .dataIn        (dataIn[2*k+1 -: 2]),
      .fillFromLeft  (fromLeft),
      .fillFromRight (fromRight),
      .dataOut       (dataOut[2*k+1 -: 2]),
      .spillLeft     (sliceSpillL[k]),
      .spillRight    (sliceSpillR[k])
    );
  end

  assign spillLeft  = sliceSpillL[NUM_SLICES-1];
  assign spillRight = sliceSpillR[0];

  // Relations between the word ends and the chained slices
  always_comb begin
    if (!shiftRight) begin
      AST_LEFT_LOW_ZERO: assert (dataOut[0] == 1'b0);          // R1
      AST_LEFT_SPILL_TOP: assert (spillLeft == dataIn[TOP]);   // R5
      AST_LEFT_NO_RSPILL: assert (spillRight == 1'b0);         // R6
    end else begin
      AST_RIGHT_SPILL_LOW: assert (spillRight == dataIn[0]);   // R6
      AST_RIGHT_NO_LSPILL: assert (spillLeft == 1'b0);         // R5
      if (arithMode) begin
        AST_SIGN_HELD: assert (dataOut[TOP] == dataIn[TOP]);   // R4
      end else begin
        AST_RIGHT_TOP_ZERO: assert (dataOut[TOP] == 1'b0);     // R3
      end
    end
    AST_ONE_SPILL: assert ($onehot0({spillLeft, spillRight})); // R5
  end

endmodule

// File: tb/chain_shifter_tb_top.sv
module chain_shifter_tb_top;

  localparam int unsigned SLICES = 4;
  localparam int unsigned W      = 2 * SLICES;

  typedef struct {
    logic [W-1:0] expData;
    logic         expSl;
    logic         expSr;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         shiftRight = 1'b0;
  logic         arithMode = 1'b0;
  logic [W-1:0] dataOut;
  logic         spillLeft;
  logic         spillRight;

  item_t queueQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    driveDone = 1'b0;

  always #10 clk = ~clk;

  chain_shifter #(.NUM_SLICES(SLICES)) dut_i (
    .dataIn     (dataIn),
    .shiftRight (shiftRight),
    .arithMode  (arithMode),
    .dataOut    (dataOut),
    .spillLeft  (spillLeft),
    .spillRight (spillRight)
  );

  function automatic item_t model(logic [W-1:0] d, logic r, logic a, string tag);
    item_t it;
    if (!r) begin
      it.expData = {d[W-2:0], 1'b0};
      it.expSl   = d[W-1];
      it.expSr   = 1'b0;
    end else begin
      it.expData = {(a ? d[W-1] : 1'b0), d[W-1:1]};
      it.expSl   = 1'b0;
      it.expSr   = d[0];
    end
    it.tag = tag;
    return it;
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] d, logic r, logic a, string tag);
    @(posedge clk);
    dataIn     <= d;
    shiftRight <= r;
    arithMode  <= a;
    queueQ.push_back(model(d, r, a, tag));
  endtask

  // monitor: compare one item per cycle, away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (queueQ.size() > 0) begin
        item_t it;
        it = queueQ.pop_front();
        check(it.tag, "dataOut", dataOut, it.expData);
        check("R5", "spillLeft", {{(W-1){1'b0}}, spillLeft}, {{(W-1){1'b0}}, it.expSl});
        check("R6", "spillRight", {{(W-1){1'b0}}, spillRight}, {{(W-1){1'b0}}, it.expSr});
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    // boundary crossings between slices (R7)
    drive(8'b0000_0010, 1'b0, 1'b0, "R7");
    drive(8'b0000_1000, 1'b0, 1'b0, "R7");
    drive(8'b0000_0100, 1'b1, 1'b0, "R7");
    drive(8'b0100_0000, 1'b1, 1'b1, "R7");
    // exhaustive sweep of every word under each direction and mode
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 256; v++) begin
        string tag;
        case (m)
          0: tag = "R1";
          1: tag = "R2";
          2: tag = "R3";
          default: tag = "R4";
        endcase
        drive(v[W-1:0], m[1], m[0], tag);
      end
    end
    // sign and end cases
    drive(8'b1000_0000, 1'b1, 1'b1, "R4");
    drive(8'b1000_0000, 1'b1, 1'b0, "R3");
    drive(8'b1000_0001, 1'b0, 1'b1, "R2");
    @(posedge clk);
    @(posedge clk);
    wait (queueQ.size() == 0);
    @(negedge clk);
    // R8: change inputs between edges and sample without any clock edge
    #3;
    dataIn = 8'b1011_0110; shiftRight = 1'b1; arithMode = 1'b1;
    #1;
    check("R8", "dataOut", dataOut, 8'b1101_1011);
    dataIn = 8'b1011_0110; shiftRight = 1'b0; arithMode = 1'b0;
    #1;
    check("R8", "dataOut", dataOut, 8'b0110_1100);
    driveDone = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 200000);
    if (!driveDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

endmodule